// File: doc/BRIEF.md
# Four-Port Wormhole Packet Switch

This block is one switching node of an on-chip packet network. It has four ports, and each port has one receive link and one transmit link. A packet is a run of 32-bit words. A head flag marks the first word and a tail flag marks the last word, and both flags travel beside the data. The low byte of the head word names one of 256 terminals. The top two bits of that byte choose the transmit port, so each port serves its own block of 64 terminals. The tail word carries the XOR of every earlier word of the packet.

Each receive link feeds a small queue. A per-input controller reads the head word, works out the target port and asks that port's arbiter for it. A port that is free goes to one requester, picked round-robin. The port then stays locked to that input until its tail word has passed. Words move one at a time into the port's transmit buffer, and the head word is sent on before the tail has arrived. The buffer absorbs short stalls downstream, so a blocked link does not push contention back into the receive queues at once. While a packet moves, the controller keeps an XOR of its words and compares it with the tail. On a mismatch it raises a one-cycle error pulse on the bit for that input, and the packet is still delivered.

Controller states: `IN_IDLE` (waiting for a head word) and `IN_XFER` (path held). `IN_IDLE -> IN_XFER` when a head word without a tail flag is forwarded. `IN_XFER -> IN_IDLE` when the tail word is forwarded. Arbiter states: `OUT_FREE` and `OUT_LOCKED`. `OUT_FREE -> OUT_LOCKED` when a granted head word that is not also a tail is taken. `OUT_LOCKED -> OUT_FREE` when the owner's tail word is taken.

Top module: `wh_router`

## Requirements
- R1: Every accepted word leaves exactly once, with its data, head flag and tail flag unchanged. Packets from one input to one output leave in the order they came in, and no word is lost under any pattern of backpressure.
- R2: The head word's bits [7:6] (the top two bits of its destination byte [7:0]) give the output port index. Every packet leaves on that port.
- R3: On each output, a packet's words leave one after another from head to tail. No word from another input comes between them.
- R4: When several inputs ask for the same free output, round-robin arbitration grants one of them at a time, and every contender is served in the end.
- R5: A head word accepted on an input at clock edge k is valid at its output after edge k+1, before its tail has been sent.
- R6: The tail word of a packet of two or more words is compared with the XOR of all earlier words. On a match, no error pulse is raised.
- R7: On a mismatch, `err_pulse[i]` for the input i is high for exactly one cycle, right after the edge at which the tail word is forwarded, and the packet is still delivered in full.
- R8: While its output is stalled, an input accepts IN_DEPTH + OUT_DEPTH words of a packet (6 by default) and then drops `in_ready`.
- R9: After reset, all `in_ready` bits are 1, and all `out_valid` and `err_pulse` bits are 0.
- R10: While `out_valid` is high and `out_ready` is low, the output keeps its data and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Receive word valid, one bit per input |
| in_data | input | 128 | Receive words, input i at bits [32i+31:32i] |
| in_head | input | 4 | First-word flag per input |
| in_tail | input | 4 | Last-word flag per input |
| in_ready | output | 4 | Receive queue has room |
| out_valid | output | 4 | Transmit word valid per output |
| out_data | output | 128 | Transmit words, output o at bits [32o+31:32o] |
| out_head | output | 4 | First-word flag per output |
| out_tail | output | 4 | Last-word flag per output |
| out_ready | input | 4 | Downstream accepts the transmit word |
| err_pulse | output | 4 | Checksum mismatch pulse, one bit per input |

## Verification
The assertions check on every cycle that each arbiter grants at most one input, and that a locked port keeps its owner until the tail is taken. They also check that every head word entering a transmit buffer sits on the port its destination bits name, that a waiting buffer word holds still, that no queue is pushed while full, and that error pulses last one cycle. Only the bench's scenarios can show the end-to-end facts. These are that whole packets arrive contiguous and in order under random contention and backpressure, the two-cycle cut-through timing of a head word, the exact fill level at which an input stalls, and that error pulses match the corrupted trailers one for one.

// File: rtl/wh_pkg.sv
package wh_pkg;
    typedef enum logic {
        IN_IDLE,
        IN_XFER
    } in_state_e;

    typedef enum logic {
        OUT_FREE,
        OUT_LOCKED
    } out_state_e;
endpackage

// File: rtl/wh_fifo.sv
module wh_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign valid = (cnt_q != '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign rdata = mem_q[rp_q];

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> (valid && $stable(rdata)));
endmodule

// File: rtl/wh_out_arb.sv
module wh_out_arb
    import wh_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         acc,
    input  logic         acc_tail,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    out_state_e    state_q, state_d;
    logic [PW-1:0] ptr_q, owner_q, win;
    logic          win_any;

    // round-robin search starting at the pointer
    always_comb begin
        win     = '0;
        win_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr_q) + k) % N;
            if (!win_any && req[j]) begin
                win_any = 1'b1;
                win     = PW'(j);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_FREE:   if (acc && !acc_tail) state_d = OUT_LOCKED;
            OUT_LOCKED: if (acc && acc_tail)  state_d = OUT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_FREE;
            ptr_q   <= '0;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == OUT_FREE && acc) begin
                owner_q <= win;
                ptr_q   <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
            end
        end
    end

    always_comb begin
        gnt = '0;
        unique case (state_q)
            OUT_FREE:   if (win_any) gnt[win] = 1'b1;
            OUT_LOCKED: gnt[owner_q] = 1'b1;
        endcase
    end

    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt & req));
    a_r3_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_LOCKED && !(acc && acc_tail))
            |=> (state_q == OUT_LOCKED && $stable(owner_q)));
endmodule

// File: rtl/wh_in_ctrl.sv
module wh_in_ctrl
    import wh_pkg::*;
#(
    parameter int N        = 4,
    parameter int DATA_W   = 32,
    parameter int DEST_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_valid,
    input  logic [DATA_W-1:0] f_data,
    input  logic              f_head,
    input  logic              f_tail,
    input  logic [N-1:0]      gnt_in,
    input  logic [N-1:0]      ob_ready,
    output logic [N-1:0]      req,
    output logic              f_pop,
    output logic              err_pulse
);
    localparam int PW       = (N > 1) ? $clog2(N) : 1;
    localparam int DEST_MSB = DEST_LSB + 7;

    in_state_e         state_q, state_d;
    logic [PW-1:0]     tgt_q, tgt;
    logic [DATA_W-1:0] sum_q;
    logic              err_q;
    logic              want;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_IDLE: if (f_pop && !f_tail) state_d = IN_XFER;
            IN_XFER: if (f_pop && f_tail)  state_d = IN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IN_IDLE;
            tgt_q   <= '0;
            sum_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= 1'b0;
            if (state_q == IN_IDLE && f_pop) tgt_q <= tgt;
            if (f_pop) begin
                sum_q <= f_head ? f_data : (sum_q ^ f_data);
                err_q <= f_tail && !f_head && (f_data != sum_q);
            end
        end
    end

    always_comb begin
        tgt  = tgt_q;
        want = 1'b0;
        unique case (state_q)
            IN_IDLE: begin
                tgt  = f_data[DEST_MSB -: PW];
                want = f_valid && f_head;
            end
            IN_XFER: want = f_valid;
        endcase
        req   = want ? (N'(1) << tgt) : '0;
        f_pop = |(req & gnt_in & ob_ready);
    end

    assign err_pulse = err_q;

    a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
endmodule

// File: rtl/wh_router.sv
module wh_router #(
    parameter int N_PORTS   = 4,
    parameter int DATA_W    = 32,
    parameter int DEST_LSB  = 0,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          in_valid,
    input  logic [N_PORTS*DATA_W-1:0]   in_data,
    input  logic [N_PORTS-1:0]          in_head,
    input  logic [N_PORTS-1:0]          in_tail,
    output logic [N_PORTS-1:0]          in_ready,
    output logic [N_PORTS-1:0]          out_valid,
    output logic [N_PORTS*DATA_W-1:0]   out_data,
    output logic [N_PORTS-1:0]          out_head,
    output logic [N_PORTS-1:0]          out_tail,
    input  logic [N_PORTS-1:0]          out_ready,
    output logic [N_PORTS-1:0]          err_pulse
);
    localparam int FW = DATA_W + 2;
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic [FW-1:0]      f_word  [N_PORTS];
    logic [N_PORTS-1:0] f_valid;
    logic [N_PORTS-1:0] f_pop;
    logic [N_PORTS-1:0] in_full;
    logic [N_PORTS-1:0] req_m   [N_PORTS];
    logic [N_PORTS-1:0] gnt_m   [N_PORTS];
    logic [N_PORTS-1:0] gnt_t   [N_PORTS];
    logic [N_PORTS-1:0] xfer_m  [N_PORTS];
    logic [N_PORTS-1:0] ob_full;
    logic [N_PORTS-1:0] ob_ready;
    logic [N_PORTS-1:0] ob_push;
    logic [N_PORTS-1:0] ob_tail_in;
    logic [FW-1:0]      ob_wdata [N_PORTS];
    logic [FW-1:0]      ob_rdata [N_PORTS];

    assign ob_ready = ~ob_full;
    assign in_ready = ~in_full;

    // crossbar: grant transpose, transfer matrix and data mux
    always_comb begin
        for (int o = 0; o < N_PORTS; o++) begin
            ob_wdata[o] = '0;
            for (int i = 0; i < N_PORTS; i++) begin
                gnt_t[i][o]  = gnt_m[o][i];
                xfer_m[o][i] = req_m[i][o] && gnt_m[o][i] && ob_ready[o];
                ob_wdata[o]  = ob_wdata[o] | (f_word[i] & {FW{xfer_m[o][i]}});
            end
            ob_push[o]    = |xfer_m[o];
            ob_tail_in[o] = ob_wdata[o][DATA_W];
        end
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
        wh_fifo #(.W(FW), .DEPTH(IN_DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i] && in_ready[i]),
            .wdata ({in_head[i], in_tail[i], in_data[i*DATA_W +: DATA_W]}),
            .full  (in_full[i]),
            .pop   (f_pop[i]),
            .valid (f_valid[i]),
            .rdata (f_word[i])
        );

        wh_in_ctrl #(.N(N_PORTS), .DATA_W(DATA_W), .DEST_LSB(DEST_LSB)) u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .f_valid   (f_valid[i]),
            .f_data    (f_word[i][DATA_W-1:0]),
            .f_head    (f_word[i][DATA_W+1]),
            .f_tail    (f_word[i][DATA_W]),
            .gnt_in    (gnt_t[i]),
            .ob_ready  (ob_ready),
            .req       (req_m[i]),
            .f_pop     (f_pop[i]),
            .err_pulse (err_pulse[i])
        );
    end

    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        wh_out_arb #(.N(N_PORTS)) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      ({<<{req_col(o)}}),
            .acc      (ob_push[o]),
            .acc_tail (ob_tail_in[o]),
            .gnt      (gnt_m[o])
        );

        wh_fifo #(.W(FW), .DEPTH(OUT_DEPTH)) u_ob (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (ob_push[o]),
            .wdata (ob_wdata[o]),
            .full  (ob_full[o]),
            .pop   (out_valid[o] && out_ready[o]),
            .valid (out_valid[o]),
            .rdata (ob_rdata[o])
        );

        assign out_data[o*DATA_W +: DATA_W] = ob_rdata[o][DATA_W-1:0];
        assign out_head[o] = ob_rdata[o][DATA_W+1];
        assign out_tail[o] = ob_rdata[o][DATA_W];

        a_r2_head_route: assert property (@(posedge clk) disable iff (!rst_n)
            (ob_push[o] && ob_wdata[o][DATA_W+1])
                |-> (ob_wdata[o][DEST_LSB+7 -: PW] == PW'(o)));
    end

    // column o of the request matrix, bit i from input i, returned reversed
    function automatic logic [N_PORTS-1:0] req_col(input int o);
        logic [N_PORTS-1:0] c;
        for (int i = 0; i < N_PORTS; i++) c[N_PORTS-1-i] = req_m[i][o];
        return c;
    endfunction
endmodule

// File: tb/wh_router_tb.sv
module wh_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int NPK = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NP-1:0]    in_valid, in_head, in_tail, in_ready;
    logic [NP*32-1:0] in_data;
    logic [NP-1:0]    out_valid, out_head, out_tail, out_ready, err_pulse;
    logic [NP*32-1:0] out_data;

    logic        iv [NP];
    logic        ih [NP];
    logic        it [NP];
    logic [31:0] id [NP];

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            in_valid[p]         = iv[p];
            in_head[p]          = ih[p];
            in_tail[p]          = it[p];
            in_data[p*32 +: 32] = id[p];
        end
    end

    wh_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_head(in_head),
        .in_tail(in_tail), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_head(out_head),
        .out_tail(out_tail), .out_ready(out_ready), .err_pulse(err_pulse)
    );

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic hold_out = 1'b1;

    logic [31:0] pk_w   [NP][NPK+1][8];
    int          pk_len [NP][NPK+1];
    int          sent   [NP];
    int          got    [NP];
    int          bad_exp[NP];
    int          err_cnt[NP];
    int          last_idx [NP][NP];
    logic        act [NP];
    int          cur_src [NP];
    int          cur_idx [NP];
    int          cur_pos [NP];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input int src, input int idx, input logic [7:0] dest);
        return {16'($urandom), 6'(idx), 2'(src), dest};
    endfunction

    // build packet: header, payload, XOR trailer (optionally corrupted)
    task automatic build(input int src, input int idx, input int len,
                         input logic [7:0] dest, input bit corrupt);
        logic [31:0] x;
        pk_len[src][idx] = len;
        pk_w[src][idx][0] = mk_hdr(src, idx, dest);
        x = pk_w[src][idx][0];
        for (int w = 1; w < len - 1; w++) begin
            pk_w[src][idx][w] = $urandom;
            x = x ^ pk_w[src][idx][w];
        end
        pk_w[src][idx][len-1] = corrupt ? (x ^ 32'h0000_0100) : x;
        if (corrupt) bad_exp[src]++;
    endtask

    task automatic send_word(input int q, input int idx, input int w);
        @(negedge clk);
        iv[q] = 1'b1;
        id[q] = pk_w[q][idx][w];
        ih[q] = (w == 0);
        it[q] = (w == pk_len[q][idx] - 1);
        #1;
        while (!in_ready[q]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        iv[q] = 1'b0;
    endtask

    task automatic drive_port(input int q);
        for (int k = 1; k <= NPK; k++) begin
            build(q, k, 2 + int'($urandom % 5), 8'($urandom),
                  (q != 3) && ($urandom % 4 == 0));
            for (int w = 0; w < pk_len[q][k]; w++) begin
                repeat ($urandom % 3) @(negedge clk);
                send_word(q, k, w);
            end
            sent[q]++;
        end
    endtask

    // output side: random backpressure and scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int o = 0; o < NP; o++)
                out_ready[o] = hold_out ? 1'b0 : ($urandom % 4 != 0);
            #1;
            for (int i = 0; i < NP; i++) if (err_pulse[i]) err_cnt[i]++;
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    logic [31:0] d;
                    d = out_data[o*32 +: 32];
                    if (!act[o]) begin
                        check(out_head[o] == 1'b1, "R3", "word outside packet", 32'(out_head[o]), 32'd1);
                        cur_src[o] = int'(d[9:8]);
                        cur_idx[o] = int'(d[15:10]);
                        cur_pos[o] = 0;
                        act[o] = 1'b1;
                        check(d[7:6] == 2'(o), "R2", "output port", 32'(o), 32'(d[7:6]));
                        check(cur_idx[o] > last_idx[cur_src[o]][o], "R1", "packet order",
                              32'(cur_idx[o]), 32'(last_idx[cur_src[o]][o] + 1));
                        last_idx[cur_src[o]][o] = cur_idx[o];
                    end
                    if (d != pk_w[cur_src[o]][cur_idx[o]][cur_pos[o]])
                        check(1'b0, "R3", "word data", d, pk_w[cur_src[o]][cur_idx[o]][cur_pos[o]]);
                    if (out_tail[o] != (cur_pos[o] == pk_len[cur_src[o]][cur_idx[o]] - 1))
                        check(1'b0, "R1", "tail flag", 32'(out_tail[o]), 32'(!out_tail[o]));
                    cur_pos[o]++;
                    if (out_tail[o]) begin
                        act[o] = 1'b0;
                        got[cur_src[o]]++;
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int acc, stalls;
        bit r8_done;
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) begin
            iv[p] = 0; ih[p] = 0; it[p] = 0; id[p] = '0;
            sent[p] = 0; got[p] = 0; bad_exp[p] = 0; err_cnt[p] = 0;
            act[p] = 0; cur_src[p] = 0; cur_idx[p] = 0; cur_pos[p] = 0;
            pk_len[p][0] = 0;
            for (int o = 0; o < NP; o++) last_idx[p][o] = -1;
        end
        out_ready = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 4'hF, "R9", "in_ready after reset", 32'(in_ready), 32'hF);
        check(out_valid == 4'h0, "R9", "out_valid after reset", 32'(out_valid), 32'h0);
        check(err_pulse == 4'h0, "R9", "err_pulse after reset", 32'(err_pulse), 32'h0);

        // R5: head cuts through while the rest of the packet is absent
        build(0, 0, 4, 8'hC5, 1'b0);
        send_word(0, 0, 0);
        repeat (2) @(negedge clk);
        #2;
        check(out_valid[3] && out_head[3] && !out_tail[3], "R5", "head at output 3",
              32'({out_valid[3], out_head[3], out_tail[3]}), 32'b110);
        check(out_data[96 +: 32] == pk_w[0][0][0], "R5", "head data", out_data[96 +: 32], pk_w[0][0][0]);
        @(negedge clk);
        #2;
        check(out_valid[3] && out_data[96 +: 32] == pk_w[0][0][0], "R10", "stalled word held",
              out_data[96 +: 32], pk_w[0][0][0]);

        // R8: fill input 2 against a stalled output 1; trailer corrupted for R7
        build(2, 0, 8, 8'h4A, 1'b1);
        acc = 0; stalls = 0; r8_done = 0;
        while (acc < 8) begin
            @(negedge clk);
            iv[2] = 1'b1; id[2] = pk_w[2][0][acc];
            ih[2] = (acc == 0); it[2] = (acc == 7);
            #1;
            if (in_ready[2]) begin
                @(posedge clk);
                #1;
                acc++;
            end else begin
                stalls++;
                if (stalls == 5 && !r8_done) begin
                    check(acc == 6, "R8", "words taken before stall", 32'(acc), 32'd6);
                    r8_done = 1;
                    hold_out = 1'b0;
                end
            end
        end
        iv[2] = 1'b0;
        sent[2]++;
        hold_out = 1'b0;
        for (int w = 1; w < 4; w++) send_word(0, 0, w);
        sent[0]++;

        // random contention phase: R1, R3, R4, R6, R7
        for (int p = 0; p < NP; p++) begin
            fork
                automatic int q = p;
                drive_port(q);
            join_none
        end
        wait fork;
        repeat (300) @(negedge clk);

        for (int p = 0; p < NP; p++) begin
            check(got[p] == sent[p], "R1", $sformatf("packets delivered from input %0d", p),
                  32'(got[p]), 32'(sent[p]));
            check(got[p] == sent[p], "R4", $sformatf("input %0d not starved", p),
                  32'(got[p]), 32'(sent[p]));
            check(err_cnt[p] == bad_exp[p], "R7", $sformatf("error pulses input %0d", p),
                  32'(err_cnt[p]), 32'(bad_exp[p]));
        end
        check(err_cnt[3] == 0, "R6", "no pulse for clean packets", 32'(err_cnt[3]), 32'd0);
        check(out_valid == 4'h0, "R1", "buffers drained", 32'(out_valid), 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule